// File: doc/BRIEF.md
# Interrupt Request Priority Tracker

This block keeps the interrupt bookkeeping for a single processor over 256 vectors. Three bit sets are held: requests waiting to be taken, vectors currently being serviced, and a per-vector record of whether the last injection of that vector was level or edge triggered. Two registers sit next to them. The task-priority register sets a floor under which the processor does not want to be disturbed. The spurious-vector register carries a software enable bit and the vector that is handed back when an acknowledge cannot be honoured.

A source injects a vector with its trigger mode. The block raises an interrupt-pending output when a request beats the current processor priority. The processor priority is derived from the task priority and the highest vector in service. The processor then pulses an acknowledge, reads back the vector to run, and later pulses end-of-interrupt to retire the highest vector in service. An INIT message and reset both return the block to its empty, disabled state.

Top module: `irq_prio_tracker`

## Requirements
- R1: The highest set vector number has the highest priority. `pend_vector` shows the highest request and `svc_vector` the highest vector in service, and each has a valid flag that is low when its set is empty.
- R2: Injecting a vector sets its request bit. It also sets that vector's trigger bit when `inj_level` is 1 and clears it when 0. `svc_level` reports the trigger bit of the highest in-service vector.
- R3: `irq_pending` is 0 whenever the software enable (bit 8 of the spurious-vector register) is 0 or no request is set.
- R4: While the processor priority is nonzero, a request whose vector bits [7:4] are less than or equal to the processor priority's bits [7:4] does not raise `irq_pending`. Only those upper four bits are compared.
- R5: During `ack_req`, `ack_vector` returns the spurious-vector register bits [7:0] and leaves every set unchanged when any of these holds: the enable is 0, no request is set, or the task priority is nonzero and the highest request is less than or equal to the full 8-bit task priority. Otherwise it returns the highest request, whose bit leaves the request set and enters the in-service set at the clock edge.
- R6: An `eoi_req` pulse clears the highest set bit of the in-service set, and has no effect when that set is empty.
- R7: A 4-bit task-priority write stores the value in bits [7:4] with bits [3:0] zero. `tpr_nib_rd` returns bits [7:4]. An 8-bit write stores the value unchanged.
- R8: Reset or an `init_req` pulse empties all three sets, sets the spurious-vector register to 0x0FF (enable clear), and zeroes the task priority.
- R9: The processor priority equals the task priority when the task priority's bits [7:4] are at least those of the highest in-service vector, or when nothing is in service. Otherwise it is that vector's bits [7:4] with the low four bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | INIT message: return to the empty, disabled state |
| inj_valid | input | 1 | Inject `inj_vector` this cycle |
| inj_vector | input | 8 | Vector being injected |
| inj_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Processor acknowledge strobe |
| ack_vector | output | 8 | Vector returned for the acknowledge in this cycle |
| eoi_req | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Write the full task priority |
| tpr_wdata | input | 8 | Data for `tpr_wr` |
| tpr_nib_wr | input | 1 | Write the task priority through the 4-bit path |
| tpr_nib_wdata | input | 4 | Data for `tpr_nib_wr` |
| svr_wr | input | 1 | Write the spurious-vector register |
| svr_wdata | input | 9 | Bit 8 enable, bits [7:0] spurious vector |
| irq_pending | output | 1 | A request beats the processor priority |
| ppr | output | 8 | Processor priority |
| tpr_q | output | 8 | Task priority |
| tpr_nib_rd | output | 4 | Task priority through the 4-bit path |
| svr_q | output | 9 | Spurious-vector register |
| pend_valid | output | 1 | Request set not empty |
| pend_vector | output | 8 | Highest request |
| svc_valid | output | 1 | In-service set not empty |
| svc_vector | output | 8 | Highest in-service vector |
| svc_level | output | 1 | Trigger bit of `svc_vector` |

## Verification
The bench goes after the split between the two comparisons. With the task priority at 0x84 and 0x85 pending, the pending output stays low because only the class is compared, yet an acknowledge takes 0x85 because the full byte is compared. A design that used one rule for both would either raise the line or return the spurious vector. Spurious acknowledges, taken while disabled, while empty and below the task priority, are followed by a look at the request and in-service tops. A design that moved a bit anyway would show a changed top or a nonempty in-service set. End-of-interrupt is driven on an empty set, a same-vector level-then-edge injection checks that the trigger bit is overwritten rather than ORed, and the processor-priority cases cover task priority winning, in-service winning, and an equal class.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam int VEC_W    = 8;
    localparam int NUM_VEC  = 1 << VEC_W;
    localparam int CLS_W    = 4;
    localparam int SUB_W    = VEC_W - CLS_W;
    localparam int SVR_W    = VEC_W + 1;
    localparam logic [SVR_W-1:0] SVR_RESET = {1'b0, {VEC_W{1'b1}}};

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
    } hit_t;

    function automatic logic [CLS_W-1:0] cls_of(input vec_t v);
        return v[VEC_W-1:SUB_W];
    endfunction

    // Processor priority from task priority and the top in-service vector.
    function automatic vec_t calc_ppr(input vec_t tpr, input hit_t svc);
        if (!svc.valid || cls_of(tpr) >= cls_of(svc.vec))
            return tpr;
        return {cls_of(svc.vec), {SUB_W{1'b0}}};
    endfunction

    // Class-only blocking test used by the pending output.
    function automatic logic class_blocked(input vec_t req, input vec_t pri);
        return (pri != '0) && (cls_of(req) <= cls_of(pri));
    endfunction

endpackage

// File: rtl/irqt_prio_enc.sv
module irqt_prio_enc
    import irqt_pkg::*;
#(
    parameter int N      = NUM_VEC,
    parameter int WORD_W = 32
) (
    input  logic [N-1:0] bits,
    output hit_t         hit
);
    localparam int NWORDS = N / WORD_W;
    localparam int IDX_W  = $clog2(WORD_W);

    logic [NWORDS*IDX_W-1:0] word_idx;
    logic [NWORDS-1:0]       word_any;

    // Stage 1: highest set bit inside each word.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] slice;
        logic [IDX_W-1:0]  idx;
        assign slice = bits[w*WORD_W +: WORD_W];
        always_comb begin
            idx = '0;
            for (int j = 0; j < WORD_W; j++)
                if (slice[j]) idx = IDX_W'(j);
        end
        assign word_idx[w*IDX_W +: IDX_W] = idx;
        assign word_any[w]                = |slice;
    end

    // Stage 2: highest nonempty word.
    always_comb begin
        hit = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (word_any[w]) begin
                hit.valid = 1'b1;
                hit.vec   = VEC_W'(w * WORD_W) | VEC_W'(word_idx[w*IDX_W +: IDX_W]);
            end
        end
    end

endmodule

// File: rtl/irqt_vec_set.sv
module irqt_vec_set
    import irqt_pkg::*;
#(
    parameter int N      = NUM_VEC,
    parameter int WORD_W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all,
    input  logic         set_en,
    input  vec_t         set_idx,
    input  logic         clr_en,
    input  vec_t         clr_idx,
    output logic [N-1:0] bits
);
    localparam int NWORDS = N / WORD_W;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int WSEL_W = (VEC_W > IDX_W) ? VEC_W - IDX_W : 1;

    logic [WSEL_W-1:0] set_word, clr_word;
    logic [IDX_W-1:0]  set_bit,  clr_bit;

    assign set_word = WSEL_W'(set_idx >> IDX_W);
    assign clr_word = WSEL_W'(clr_idx >> IDX_W);
    assign set_bit  = set_idx[IDX_W-1:0];
    assign clr_bit  = clr_idx[IDX_W-1:0];

    // One register word per group; a set beats a clear of the same bit.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                bits[w*WORD_W +: WORD_W] <= '0;
            end else begin
                if (clr_en && clr_word == WSEL_W'(w))
                    bits[w*WORD_W + int'(clr_bit)] <= 1'b0;
                if (set_en && set_word == WSEL_W'(w))
                    bits[w*WORD_W + int'(set_bit)] <= 1'b1;
            end
        end
    end

    // R2: a requested set lands on the next edge
    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
        set_en && !clr_all |=> bits[$past(set_idx)]);

endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
    import irqt_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_req,
    input  logic             inj_valid,
    input  logic [VEC_W-1:0] inj_vector,
    input  logic             inj_level,
    input  logic             ack_req,
    output logic [VEC_W-1:0] ack_vector,
    input  logic             eoi_req,
    input  logic             tpr_wr,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             tpr_nib_wr,
    input  logic [CLS_W-1:0] tpr_nib_wdata,
    input  logic             svr_wr,
    input  logic [SVR_W-1:0] svr_wdata,
    output logic             irq_pending,
    output logic [VEC_W-1:0] ppr,
    output logic [VEC_W-1:0] tpr_q,
    output logic [CLS_W-1:0] tpr_nib_rd,
    output logic [SVR_W-1:0] svr_q,
    output logic             pend_valid,
    output logic [VEC_W-1:0] pend_vector,
    output logic             svc_valid,
    output logic [VEC_W-1:0] svc_vector,
    output logic             svc_level
);
    logic [NUM_VEC-1:0] req_bits, svc_bits, trig_bits;
    hit_t req_hit, svc_hit;
    logic sw_en, accept, ack_go, eoi_go;

    irqt_vec_set #(.N(NUM_VEC), .WORD_W(WORD_W)) u_req_set (
        .clk(clk), .rst(rst), .clr_all(init_req),
        .set_en(inj_valid), .set_idx(inj_vector),
        .clr_en(ack_go), .clr_idx(req_hit.vec),
        .bits(req_bits));

    irqt_vec_set #(.N(NUM_VEC), .WORD_W(WORD_W)) u_svc_set (
        .clk(clk), .rst(rst), .clr_all(init_req),
        .set_en(ack_go), .set_idx(req_hit.vec),
        .clr_en(eoi_go), .clr_idx(svc_hit.vec),
        .bits(svc_bits));

    irqt_vec_set #(.N(NUM_VEC), .WORD_W(WORD_W)) u_trig_set (
        .clk(clk), .rst(rst), .clr_all(init_req),
        .set_en(inj_valid && inj_level), .set_idx(inj_vector),
        .clr_en(inj_valid && !inj_level), .clr_idx(inj_vector),
        .bits(trig_bits));

    irqt_prio_enc #(.N(NUM_VEC), .WORD_W(WORD_W)) u_req_enc (
        .bits(req_bits), .hit(req_hit));

    irqt_prio_enc #(.N(NUM_VEC), .WORD_W(WORD_W)) u_svc_enc (
        .bits(svc_bits), .hit(svc_hit));

    // Task priority and spurious-vector register.
    always_ff @(posedge clk) begin
        if (rst || init_req) begin
            tpr_q <= '0;
            svr_q <= SVR_RESET;
        end else begin
            if (tpr_nib_wr) tpr_q <= {tpr_nib_wdata, {SUB_W{1'b0}}};
            if (tpr_wr)     tpr_q <= tpr_wdata;
            if (svr_wr)     svr_q <= svr_wdata;
        end
    end

    assign sw_en       = svr_q[VEC_W];
    assign tpr_nib_rd  = cls_of(tpr_q);
    assign ppr         = calc_ppr(tpr_q, svc_hit);

    // Acceptance compares the full byte against the task priority.
    assign accept      = sw_en && req_hit.valid &&
                         !((tpr_q != '0) && (req_hit.vec <= tpr_q));
    assign ack_go      = ack_req && accept && !init_req;
    assign eoi_go      = eoi_req && svc_hit.valid && !init_req;
    assign ack_vector  = accept ? req_hit.vec : svr_q[VEC_W-1:0];

    // The pending line compares only the class against the processor priority.
    assign irq_pending = sw_en && req_hit.valid && !class_blocked(req_hit.vec, ppr);

    assign pend_valid  = req_hit.valid;
    assign pend_vector = req_hit.vec;
    assign svc_valid   = svc_hit.valid;
    assign svc_vector  = svc_hit.vec;
    assign svc_level   = svc_hit.valid && trig_bits[svc_hit.vec];

    // R5: an accepted vector shows up in service on the next edge
    a_r5_accept_moves: assert property (@(posedge clk) disable iff (rst)
        ack_req && accept && !init_req |=> svc_valid && svc_vector >= $past(ack_vector));

    // R5: a spurious acknowledge leaves both sets as they were
    a_r5_spurious_keeps: assert property (@(posedge clk) disable iff (rst)
        ack_req && !accept && !inj_valid && !eoi_req && !init_req
        |=> $stable(pend_vector) && $stable(pend_valid) &&
            $stable(svc_vector) && $stable(svc_valid));

    // R6: end-of-interrupt lowers or empties the in-service top
    a_r6_eoi_lowers: assert property (@(posedge clk) disable iff (rst)
        eoi_req && svc_valid && !ack_req && !init_req
        |=> !svc_valid || svc_vector < $past(svc_vector));

    // R7: the 4-bit path stores into the upper nibble
    a_r7_nib_store: assert property (@(posedge clk) disable iff (rst)
        tpr_nib_wr && !tpr_wr && !init_req
        |=> tpr_q == {$past(tpr_nib_wdata), {SUB_W{1'b0}}});

    // R8: INIT empties the sets and restores the registers
    a_r8_init_clears: assert property (@(posedge clk) disable iff (rst)
        init_req |=> !pend_valid && !svc_valid && svr_q == SVR_RESET && tpr_q == '0);

    // R9: processor priority never falls below task priority
    a_r9_ppr_floor: assert property (@(posedge clk) disable iff (rst)
        ppr >= tpr_q);

    // R3: pending requires the software enable
    a_r3_pend_needs_en: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> svr_q[VEC_W] && pend_valid);

endmodule

// File: tb/irq_prio_tracker_bench.sv
module irq_prio_tracker_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_req = 0, inj_valid = 0, inj_level = 0, ack_req = 0, eoi_req = 0;
    logic tpr_wr = 0, tpr_nib_wr = 0, svr_wr = 0;
    logic [7:0] inj_vector = 0, tpr_wdata = 0;
    logic [3:0] tpr_nib_wdata = 0;
    logic [8:0] svr_wdata = 0;
    logic [7:0] ack_vector, ppr, tpr_q, pend_vector, svc_vector;
    logic [3:0] tpr_nib_rd;
    logic [8:0] svr_q;
    logic irq_pending, pend_valid, svc_valid, svc_level;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_prio_tracker u_irq_prio_tracker (
        .clk(clk), .rst(rst), .init_req(init_req),
        .inj_valid(inj_valid), .inj_vector(inj_vector), .inj_level(inj_level),
        .ack_req(ack_req), .ack_vector(ack_vector), .eoi_req(eoi_req),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
        .tpr_nib_wr(tpr_nib_wr), .tpr_nib_wdata(tpr_nib_wdata),
        .svr_wr(svr_wr), .svr_wdata(svr_wdata),
        .irq_pending(irq_pending), .ppr(ppr), .tpr_q(tpr_q), .tpr_nib_rd(tpr_nib_rd),
        .svr_q(svr_q), .pend_valid(pend_valid), .pend_vector(pend_vector),
        .svc_valid(svc_valid), .svc_vector(svc_vector), .svc_level(svc_level));

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic inject(input logic [7:0] v, input logic lvl);
        @(negedge clk); inj_valid = 1; inj_vector = v; inj_level = lvl;
        @(negedge clk); inj_valid = 0;
    endtask

    task automatic ack_expect(input string req, input logic [7:0] exp);
        @(negedge clk); ack_req = 1; #1;
        check(req, ack_vector, exp);
        @(negedge clk); ack_req = 0;
    endtask

    task automatic eoi;
        @(negedge clk); eoi_req = 1;
        @(negedge clk); eoi_req = 0;
    endtask

    task automatic write_svr(input logic [8:0] v);
        @(negedge clk); svr_wr = 1; svr_wdata = v;
        @(negedge clk); svr_wr = 0;
    endtask

    task automatic write_tpr(input logic [7:0] v);
        @(negedge clk); tpr_wr = 1; tpr_wdata = v;
        @(negedge clk); tpr_wr = 0;
    endtask

    task automatic write_tpr_nib(input logic [3:0] v);
        @(negedge clk); tpr_nib_wr = 1; tpr_nib_wdata = v;
        @(negedge clk); tpr_nib_wr = 0;
    endtask

    task automatic t_reset_state;
        check("R8 reset svr", svr_q, 9'h0FF);
        check("R8 reset tpr", tpr_q, 0);
        check("R8 reset pend_valid", pend_valid, 0);
        check("R8 reset svc_valid", svc_valid, 0);
        check("R3 reset irq_pending", irq_pending, 0);
        check("R9 reset ppr", ppr, 0);
        ack_expect("R5 ack on empty", 8'hFF);
    endtask

    task automatic t_disabled;
        inject(8'h31, 0);
        check("R1 pend_vector", pend_vector, 8'h31);
        check("R3 disabled no pending", irq_pending, 0);
        ack_expect("R5 ack while disabled", 8'hFF);
        check("R5 disabled ack keeps request", pend_vector, 8'h31);
        check("R5 disabled ack nothing in service", svc_valid, 0);
        write_svr(9'h1E7);
        check("R3 enabled pending", irq_pending, 1);
    endtask

    task automatic t_priority_and_block;
        inject(8'h45, 0);
        inject(8'h80, 0);
        check("R1 highest request", pend_vector, 8'h80);
        ack_expect("R5 ack highest", 8'h80);
        check("R5 moved in service", svc_vector, 8'h80);
        check("R5 request cleared", pend_vector, 8'h45);
        check("R9 ppr from service", ppr, 8'h80);
        check("R4 lower class blocked", irq_pending, 0);
        inject(8'h85, 0);
        check("R4 equal class blocked", irq_pending, 0);
        inject(8'h90, 0);
        check("R4 higher class passes", irq_pending, 1);
        ack_expect("R5 nested ack", 8'h90);
        check("R9 ppr nested", ppr, 8'h90);
    endtask

    task automatic t_eoi;
        eoi;
        check("R6 eoi clears highest", svc_vector, 8'h80);
        check("R9 ppr after eoi", ppr, 8'h80);
        check("R4 still blocked", irq_pending, 0);
        eoi;
        check("R6 second eoi empties", svc_valid, 0);
        check("R9 ppr zero", ppr, 0);
        check("R4 unblocked", irq_pending, 1);
        eoi;
        check("R6 eoi on empty", svc_valid, 0);
        check("R6 eoi on empty keeps requests", pend_vector, 8'h85);
    endtask

    task automatic t_trigger;
        inject(8'hA0, 1);
        ack_expect("R2 level ack", 8'hA0);
        check("R2 level bit", svc_level, 1);
        eoi;
        inject(8'hA0, 0);
        ack_expect("R2 edge ack", 8'hA0);
        check("R2 edge clears bit", svc_level, 0);
        eoi;
        check("R6 back to empty", svc_valid, 0);
    endtask

    task automatic t_task_priority;
        write_tpr_nib(4'h9);
        check("R7 nibble stored", tpr_q, 8'h90);
        check("R7 nibble read", tpr_nib_rd, 4'h9);
        check("R9 ppr from tpr", ppr, 8'h90);
        check("R4 below tpr blocked", irq_pending, 0);
        ack_expect("R5 spurious below tpr", 8'hE7);
        check("R5 spurious keeps request", pend_vector, 8'h85);
        check("R5 spurious nothing in service", svc_valid, 0);
        write_tpr(8'h84);
        check("R7 full write", tpr_q, 8'h84);
        check("R4 class-only block", irq_pending, 0);
        ack_expect("R5 full-byte accept", 8'h85);
        check("R9 tpr class equal wins", ppr, 8'h84);
        write_tpr(8'h21);
        check("R9 service class wins", ppr, 8'h80);
    endtask

    task automatic t_init;
        @(negedge clk); init_req = 1;
        @(negedge clk); init_req = 0;
        check("R8 init svr", svr_q, 9'h0FF);
        check("R8 init tpr", tpr_q, 0);
        check("R8 init requests", pend_valid, 0);
        check("R8 init service", svc_valid, 0);
        check("R8 init ppr", ppr, 0);
        inject(8'h10, 0);
        check("R8 init left disabled", irq_pending, 0);
        check("R1 new request", pend_vector, 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_state();
        t_disabled();
        t_priority_and_block();
        t_eoi();
        t_trigger();
        t_task_priority();
        t_init();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule